// File: doc/BRIEF.md
# Watchdog Timer with Timebase

This block is a watchdog with a free-running timebase counter. Software reaches both through a 32-bit register port. Once software enables the watchdog, an internal counter runs through a period of 2^TIMEOUT_LOG2 clock cycles.

Expiry happens in two stages:
- At the end of the first period the watchdog raises an expired flag and an interrupt.
- If that flag is still set at the end of the next period, the block issues a one-cycle reset request.

That request also resets the block itself: the watchdog and the timebase return to idle. A sticky status bit survives this reset, so software can later tell that the last reset came from the watchdog. Only the external reset clears it, apart from a software write-one-to-clear.

A parameter fixes the enable behaviour. In locked mode the enable cannot be cleared once it is set. In free mode software can turn the watchdog on and off at will. The timebase counts every clock cycle. It raises a pending interrupt each time it wraps from all ones to zero.

Top module: `wdt_timebase`

## Requirements
- R1: While rst_ni is low, all outputs are 0 and the registers at offsets 0, 4 and 8 read 0.
- R2: Offset 0 (control) holds enable in bit 0, expired in bit 1 and watchdog-reset status in bit 2. Exactly 2^TIMEOUT_LOG2 clock edges after the edge that writes enable = 1, the expired bit and irq_wdt_o become 1.
- R3: If the expired bit is still 1 when the next period ends, wdt_rst_o is 1 for exactly one cycle, on the edge 2^TIMEOUT_LOG2 cycles after the first expiry.
- R4: Writing 1 to control bit 1, with bit 0 kept at 1, clears the expired flag without restarting the count. The following expiry then sets the flag again and does not raise wdt_rst_o.
- R5: On the edge after wdt_rst_o is high, the enable, the counter, the expired flag, the timebase and the timebase pending bit are cleared, and control bit 2 is set. Control then reads 4 and the timebase reads 0.
- R6: Control bit 2 is cleared by writing 1 to it and by rst_ni. The watchdog reset does not clear it.
- R7: With ENABLE_ONCE = 1, a control write with bit 0 = 0 leaves the enable set and the period unchanged. With ENABLE_ONCE = 0, such a write disables the watchdog and clears the counter and the expired flag.
- R8: Offset 4 reads the timebase, zero-extended to 32 bits. The timebase increments by one on every clock edge, starting from 0 after reset.
- R9: On the edge where the timebase wraps from all ones to 0, offset 8 bit 1 and irq_tb_o become 1. Writing 1 to offset 8 bit 1 clears them.
- R10: Offset 8 bit 0 mirrors the expired flag. Writes to offset 4 have no effect on the timebase. Offset 12 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous external reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| irq_wdt_o | output | 1 | Watchdog first-expiry interrupt (level) |
| irq_tb_o | output | 1 | Timebase rollover interrupt (level) |
| wdt_rst_o | output | 1 | One-cycle reset request on second expiry |

## Verification
Assertions check the following on every cycle:
- the reset request is a single-cycle pulse, and it only follows a cycle with the expired flag set;
- the cleanup after that pulse, with the status bit set;
- the lock of the enable in locked mode, and immediate disabling in free mode;
- the timebase stepping by one, and its pending bit after a wrap.

The exact cycle counts of both expiries, the effect of servicing, and address decode can only be shown by the bench's timed scenarios. The same holds for the survival of the status bit and the full rollover sweep.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned WORD_CTRL = 0;
  localparam int unsigned WORD_TB   = 1;
  localparam int unsigned WORD_ISR  = 2;

  localparam int unsigned CTRL_EN  = 0;
  localparam int unsigned CTRL_EXP = 1;
  localparam int unsigned CTRL_STS = 2;

  localparam int unsigned ISR_WDT = 0;
  localparam int unsigned ISR_TB  = 1;

  typedef struct packed {
    logic       ctrl_wr;
    logic       isr_wr;
    logic [2:0] bits;
  } wr_req_t;
endpackage

// File: rtl/wdt_reg_if.sv
module wdt_reg_if
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned TB_W   = 32
) (
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              en_i,
  input  logic              expired_i,
  input  logic              status_i,
  input  logic [TB_W-1:0]   tb_i,
  input  logic              tb_pend_i,
  output wr_req_t           req_o,
  output logic [31:0]       rdata_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              unused_wdata;

  assign word         = reg_addr_i[ADDR_W-1:2];
  assign aligned      = (reg_addr_i[1:0] == 2'b00);
  assign unused_wdata = ^reg_wdata_i[31:3];

  always_comb begin
    req_o.bits    = reg_wdata_i[2:0];
    req_o.ctrl_wr = reg_wr_i && aligned && (word == WORD_W'(WORD_CTRL));
    req_o.isr_wr  = reg_wr_i && aligned && (word == WORD_W'(WORD_ISR));
  end

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      if (word == WORD_W'(WORD_CTRL)) begin
        rdata_o[CTRL_EN]  = en_i;
        rdata_o[CTRL_EXP] = expired_i;
        rdata_o[CTRL_STS] = status_i;
      end else if (word == WORD_W'(WORD_TB)) begin
        rdata_o = 32'(tb_i);
      end else if (word == WORD_W'(WORD_ISR)) begin
        rdata_o[ISR_WDT] = expired_i;
        rdata_o[ISR_TB]  = tb_pend_i;
      end
    end
  end

  always_comb begin
    a_one_strobe_r10: assert (!(req_o.ctrl_wr && req_o.isr_wr));
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter bit          ENABLE_ONCE = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_wr_i,
  input  logic [2:0] ctrl_d_i,
  output logic       en_o,
  output logic       expired_o,
  output logic       status_o,
  output logic       bite_o
);
  logic [CNT_W-1:0] cnt;
  logic             en_nxt;
  logic             expire;

  assign expire = en_o && (cnt == '1);

  // enable-write policy is a build-time variant
  generate
    if (ENABLE_ONCE) begin : g_locked
      assign en_nxt = en_o | (ctrl_wr_i & ctrl_d_i[CTRL_EN]);
    end else begin : g_free
      assign en_nxt = ctrl_wr_i ? ctrl_d_i[CTRL_EN] : en_o;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o      <= 1'b0;
      cnt       <= '0;
      expired_o <= 1'b0;
      bite_o    <= 1'b0;
      status_o  <= 1'b0;
    end else if (bite_o) begin
      // watchdog reset: everything but the sticky status returns to idle
      en_o      <= 1'b0;
      cnt       <= '0;
      expired_o <= 1'b0;
      bite_o    <= 1'b0;
      status_o  <= 1'b1;
    end else begin
      en_o   <= en_nxt;
      bite_o <= expire && expired_o;
      if (!en_nxt)   cnt <= '0;
      else if (en_o) cnt <= cnt + 1'b1;
      if (!en_nxt)                              expired_o <= 1'b0;
      else if (expire)                          expired_o <= 1'b1;
      else if (ctrl_wr_i && ctrl_d_i[CTRL_EXP]) expired_o <= 1'b0;
      if (ctrl_wr_i && ctrl_d_i[CTRL_STS]) status_o <= 1'b0;
    end
  end

  p_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bite_o |=> !bite_o);
  p_bite_after_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bite_o) |-> $past(expired_o));
  p_soft_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bite_o |=> (!en_o && !expired_o && cnt == '0 && status_o));
  p_status_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && !(ctrl_wr_i && ctrl_d_i[CTRL_STS])) |=> status_o);

  generate
    if (ENABLE_ONCE) begin : g_chk_locked
      p_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_o && !bite_o) |=> en_o);
    end else begin : g_chk_free
      p_disable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_wr_i && !ctrl_d_i[CTRL_EN]) |=> (!en_o && !expired_o && cnt == '0));
    end
  endgenerate
endmodule

// File: rtl/wdt_tbase.sv
module wdt_tbase #(
  parameter int unsigned TB_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            pend_clr_i,
  output logic [TB_W-1:0] tb_o,
  output logic            pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tb_o   <= '0;
      pend_o <= 1'b0;
    end else if (clr_i) begin
      tb_o   <= '0;
      pend_o <= 1'b0;
    end else begin
      tb_o <= tb_o + 1'b1;
      if (tb_o == '1)      pend_o <= 1'b1;
      else if (pend_clr_i) pend_o <= 1'b0;
    end
  end

  p_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> tb_o == TB_W'($past(tb_o) + 1'b1));
  p_wrap_pend_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tb_o == '1 && !clr_i) |=> pend_o);
endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase
  import wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_LOG2 = 16,
  parameter int unsigned TB_W         = 32,
  parameter bit          ENABLE_ONCE  = 1'b0,
  parameter int unsigned ADDR_W       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_wdt_o,
  output logic              irq_tb_o,
  output logic              wdt_rst_o
);
  wr_req_t         req;
  logic            en, expired, status, bite, tb_pend;
  logic [TB_W-1:0] tb;

  wdt_reg_if #(.ADDR_W(ADDR_W), .TB_W(TB_W)) i_reg_if (
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .en_i       (en),
    .expired_i  (expired),
    .status_i   (status),
    .tb_i       (tb),
    .tb_pend_i  (tb_pend),
    .req_o      (req),
    .rdata_o    (reg_rdata_o)
  );

  wdt_core #(.CNT_W(TIMEOUT_LOG2), .ENABLE_ONCE(ENABLE_ONCE)) i_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_wr_i(req.ctrl_wr),
    .ctrl_d_i (req.bits),
    .en_o     (en),
    .expired_o(expired),
    .status_o (status),
    .bite_o   (bite)
  );

  wdt_tbase #(.TB_W(TB_W)) i_tbase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (bite),
    .pend_clr_i(req.isr_wr && req.bits[ISR_TB]),
    .tb_o      (tb),
    .pend_o    (tb_pend)
  );

  assign irq_wdt_o = expired;
  assign irq_tb_o  = tb_pend;
  assign wdt_rst_o = bite;
endmodule

// File: tb/test_wdt_timebase.sv
module test_wdt_timebase;
  localparam int unsigned LOG2 = 4;
  localparam int unsigned TBW  = 8;
  localparam int          PER  = 1 << LOG2;
  localparam int          TBM  = 1 << TBW;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr = 1'b0;
  logic        sel = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        irqw_a, irqt_a, rst_a, irqw_b, irqt_b, rst_b;
  int          n_vec = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  wdt_timebase #(.TIMEOUT_LOG2(LOG2), .TB_W(TBW), .ENABLE_ONCE(1'b0)) i_wdt_timebase (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(wr && !sel), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata_a), .irq_wdt_o(irqw_a),
    .irq_tb_o(irqt_a), .wdt_rst_o(rst_a));

  wdt_timebase #(.TIMEOUT_LOG2(LOG2), .TB_W(TBW), .ENABLE_ONCE(1'b1)) i_wdt_timebase_once (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(wr && sel), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata_b), .irq_wdt_o(irqw_b),
    .irq_tb_o(irqt_b), .wdt_rst_o(rst_b));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(logic s, logic [3:0] a, logic [31:0] d);
    sel = s; addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd(logic s, logic [3:0] a, output logic [31:0] v);
    sel = s; addr = a;
    #1;
    v = s ? rdata_b : rdata_a;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    tick(2);
    // R1 reset state
    rd(0, 4'h0, v); chk("R1 ctrl", v, 0);
    rd(0, 4'h4, v); chk("R1 tb", v, 0);
    rd(0, 4'h8, v); chk("R1 isr", v, 0);
    chk("R1 outputs", {26'd0, irqw_a, irqt_a, rst_a, irqw_b, irqt_b, rst_b}, 0);
    rst_ni = 1'b1;

    // R8/R9 timebase sweep across a wrap
    for (int k = 1; k <= 300; k++) begin
      tick(1);
      rd(0, 4'h4, v); chk("R8 tb count", v, k % TBM);
      rd(0, 4'h8, v); chk("R9 isr pend", v, (k >= TBM) ? 2 : 0);
      chk("R9 irq_tb", irqt_a, (k >= TBM) ? 1 : 0);
    end
    wr_reg(0, 4'h8, 32'h3);
    rd(0, 4'h8, v); chk("R9 w1c isr", v, 0);
    chk("R9 irq_tb clear", irqt_a, 0);

    // R2 first expiry, free instance
    wr_reg(0, 4'h0, 32'h1);
    tick(PER - 1);
    rd(0, 4'h0, v); chk("R2 before expiry", v, 1);
    chk("R2 irq before", irqw_a, 0);
    tick(1);
    rd(0, 4'h0, v); chk("R2 expired", v, 3);
    chk("R2 irq_wdt", irqw_a, 1);
    rd(0, 4'h8, v); chk("R10 isr mirrors expired", v[0], 1);
    // R4 service, count not restarted
    tick(3);
    wr_reg(0, 4'h0, 32'h3);
    rd(0, 4'h0, v); chk("R4 serviced", v, 1);
    chk("R4 irq cleared", irqw_a, 0);
    tick(PER - 5);
    rd(0, 4'h0, v); chk("R4 before 2nd expiry", v, 1);
    tick(1);
    rd(0, 4'h0, v); chk("R4 flag again", v, 3);
    chk("R4 no reset", rst_a, 0);
    // R3 unserviced expiry
    for (int k = 1; k < PER; k++) begin
      tick(1); chk("R3 no early reset", rst_a, 0);
    end
    tick(1); chk("R3 reset pulse", rst_a, 1);
    tick(1); chk("R3 pulse one cycle", rst_a, 0);
    // R5 cleanup
    rd(0, 4'h0, v); chk("R5 ctrl after bite", v, 4);
    rd(0, 4'h4, v); chk("R5 tb cleared", v, 0);
    rd(0, 4'h8, v); chk("R5 isr cleared", v, 0);
    chk("R5 irq_wdt low", irqw_a, 0);
    tick(1);
    rd(0, 4'h4, v); chk("R5 tb restarts", v, 1);
    rd(0, 4'h0, v); chk("R6 status survives", v, 4);
    // R6 w1c status
    wr_reg(0, 4'h0, 32'h4);
    rd(0, 4'h0, v); chk("R6 status w1c", v, 0);

    // R7 free mode disable
    wr_reg(0, 4'h0, 32'h1);
    tick(5);
    wr_reg(0, 4'h0, 32'h0);
    rd(0, 4'h0, v); chk("R7 free disable", v, 0);
    for (int k = 0; k < 2 * PER + 2; k++) begin
      tick(1);
      chk("R7 disabled no expiry", {30'd0, irqw_a, rst_a}, 0);
    end

    // R10 decode
    rd(0, 4'h4, v);
    wr_reg(0, 4'h4, 32'hff);
    rd(0, 4'h4, v2); chk("R10 tb write ignored", v2, (v + 1) % TBM);
    rd(0, 4'hC, v); chk("R10 offset 12", v, 0);

    // R7 locked instance
    wr_reg(1, 4'h0, 32'h1);
    tick(2);
    wr_reg(1, 4'h0, 32'h0);
    rd(1, 4'h0, v); chk("R7 locked enable", v, 1);
    tick(PER - 4);
    rd(1, 4'h0, v); chk("R7 locked period kept", v, 1);
    tick(1);
    rd(1, 4'h0, v); chk("R7 locked expiry", v, 3);
    chk("R2 irq_wdt locked", irqw_b, 1);
    tick(PER - 1); chk("R3 locked no early", rst_b, 0);
    tick(1); chk("R3 locked pulse", rst_b, 1);
    tick(1);
    rd(1, 4'h0, v); chk("R5 locked after bite", v, 4);
    // R6 external reset clears status
    rst_ni = 1'b0;
    #1;
    rd(1, 4'h0, v); chk("R6 rst_ni clears status", v, 0);
    chk("R1 outputs in reset", {29'd0, irqw_b, irqt_b, rst_b}, 0);
    summary();
    $finish;
  end
endmodule